// File: doc/BRIEF.md
# Indirect Register Read Port

This block is the host-side access path into a four-channel signal-processing core. The host sees only eight direct locations on a 3-bit address bus. To read a value it writes a 16-bit indirect address to the read-select location. The upper nibble of that address names a channel and the lower twelve bits name a source inside it. The 32-bit result is then read as two 16-bit halves at two other locations. To write, the host stages two 16-bit halves and then writes an indirect address to the write-commit location.

Sources come in two kinds. Plain registers (carrier and timing frequency words, a wait preload word) and the latched gain snapshot are live: the holding register follows them every cycle, so repeated reads show changes with no further host action. Memory-backed sources are strobed. These are an instruction RAM, two coefficient RAMs and two computed coefficient ROMs. Writing their address raises a one-cycle fetch strobe, and one synchronous read fills the holding register. The value then stays fixed until the address is written again. A write-commit to offset 00F captures the gain inputs of all four channels on the same edge. Reads of offset 00F return that snapshot.

Top module: `indirect_read_port`

## Requirements
- R1: After reset, reads at direct locations 0 and 1 return zero and `fetch_stb` is low.
- R2: Direct map. Read location 0 returns bits 15:0 of the holding register and location 1 returns bits 31:16. Every other location reads zero. Writes to location 4 stage data bits 15:0, writes to location 5 stage bits 31:16, a write to location 2 commits the staged word to the indirect address written, and a write to location 3 selects the read source.
- R3: A location-3 write of a memory-backed offset with a valid nibble raises `fetch_stb` for exactly the next cycle. For any other offset `fetch_stb` stays low. The selected value is readable from the second rising edge after the write edge. Memory-backed offsets are 100–1FC (instruction RAM), 400–43F (coefficient ROM), 440–47F (coefficient RAM A), 480–4FF (coefficient RAM B) and 500–5FF (resampler ROM).
- R4: After a fetch, writing new contents to the fetched memory word does not change what is read until location 3 is written again.
- R5: The live offsets are 006 (carrier frequency), 00C (wait preload), 009 (timing frequency) and 00F (gain snapshot). While one of them is selected, a change to its register shows on the read port from the edge after the change, with no reselect.
- R6: Indirect address bits 15:12 select the channel. Values 0–3 pick that channel. F reads channel 0 and makes a commit write to all four channels. Values 4–E read zero and their commit writes are dropped.
- R7: Offsets outside the map, including 1FD–1FF, read zero and raise no strobe. Commit writes to ROM offsets have no effect.
- R8: A commit write to offset 00F latches every channel's `agc_gain_in` slice on that edge, whatever the nibble. The staged data is not used.
- R9: A read of offset 00F returns the latched snapshot, not the present gain input.
- R10: Coefficient ROM word i (offset 400+i, i in 0..63) is {(i*i) mod 2^16, C000h OR i}. Resampler ROM word j (offset 500+j) is {j, bitwise NOT j, (3*j) mod 2^16}, with the first two fields 8 bits each.
- R11: A gain snapshot reads in bits 15:0, and bits 31:16 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_addr | input | 3 | Direct location |
| host_wdata | input | 16 | Host write data |
| host_we | input | 1 | Write enable, one write per high cycle |
| host_rdata | output | 16 | Combinational read data |
| agc_gain_in | input | 64 | Present gain of each channel, channel c in bits 16c+15:16c |
| fetch_stb | output | 1 | One-cycle fetch strobe for memory-backed sources |

## Verification
The host read port is combinational, so a read is sampled in the same cycle its address is driven. `fetch_stb` is due in the cycle after the write edge. The holding register is due after the second edge, and a live register change is due one edge after the commit. The gain snapshot takes the inputs present before the commit edge. The bench's write task returns just after the write edge, strobe checks are sampled at the following falling edge, and every read check first waits for a further rising edge. That ordering keeps each comparison on the cycle its result is due. Changing the gain inputs right after the commit shows whether the snapshot came from the correct edge.

// File: rtl/irp_pkg.sv
package irp_pkg;
  localparam int OFF_W  = 12;
  localparam int NIB_W  = 4;
  localparam int IDX_W  = 8;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  localparam int IRAM_DEPTH  = 256;
  localparam int CRAM1_DEPTH = 64;
  localparam int CRAM2_DEPTH = 128;
  localparam int IRAM_AW  = $clog2(IRAM_DEPTH);
  localparam int CRAM1_AW = $clog2(CRAM1_DEPTH);
  localparam int CRAM2_AW = $clog2(CRAM2_DEPTH);

  localparam logic [2:0] DA_RD_LO = 3'd0;
  localparam logic [2:0] DA_RD_HI = 3'd1;
  localparam logic [2:0] DA_IWA   = 3'd2;
  localparam logic [2:0] DA_IRA   = 3'd3;
  localparam logic [2:0] DA_WD_LO = 3'd4;
  localparam logic [2:0] DA_WD_HI = 3'd5;

  localparam logic [NIB_W-1:0] NIB_ALL = 4'hF;

  typedef enum logic [3:0] {
    SRC_NONE, SRC_CNCO, SRC_WAIT, SRC_TNCO, SRC_AGC,
    SRC_IRAM, SRC_CROM, SRC_CRAM1, SRC_CRAM2, SRC_RROM
  } src_e;

  function automatic logic src_is_mem(input src_e s);
    return (s == SRC_IRAM) || (s == SRC_CROM) || (s == SRC_CRAM1) ||
           (s == SRC_CRAM2) || (s == SRC_RROM);
  endfunction

  function automatic logic src_is_rom(input src_e s);
    return (s == SRC_CROM) || (s == SRC_RROM);
  endfunction

  // coefficient table: square of the index above, tagged index below
  function automatic logic [WORD_W-1:0] crom_word(input logic [5:0] i);
    logic [15:0] w;
    w = {10'd0, i};
    return {w * w, 16'hC000 | w};
  endfunction

  // resampler table: index, its complement, triple of the index
  function automatic logic [WORD_W-1:0] rrom_word(input logic [7:0] j);
    logic [15:0] w;
    w = {8'd0, j};
    return {j, ~j, w * 16'd3};
  endfunction
endpackage

// File: rtl/irp_decode.sv
module irp_decode
  import irp_pkg::*;
(
  input  logic [OFF_W-1:0] off,
  output src_e             src,
  output logic [IDX_W-1:0] idx,
  output logic             strobed
);
  always_comb begin
    src = SRC_NONE;
    idx = '0;
    if (off == 12'h006)      src = SRC_CNCO;
    else if (off == 12'h00C) src = SRC_WAIT;
    else if (off == 12'h009) src = SRC_TNCO;
    else if (off == 12'h00F) src = SRC_AGC;
    else if (off >= 12'h100 && off <= 12'h1FC) begin
      src = SRC_IRAM;
      idx = off[7:0];
    end else if (off >= 12'h400 && off <= 12'h43F) begin
      src = SRC_CROM;
      idx = {2'b00, off[5:0]};
    end else if (off >= 12'h440 && off <= 12'h47F) begin
      src = SRC_CRAM1;
      idx = {2'b00, off[5:0]};
    end else if (off >= 12'h480 && off <= 12'h4FF) begin
      src = SRC_CRAM2;
      idx = {1'b0, off[6:0]};
    end else if (off >= 12'h500 && off <= 12'h5FF) begin
      src = SRC_RROM;
      idx = off[7:0];
    end
    strobed = src_is_mem(src);
  end
endmodule

// File: rtl/irp_rom.sv
module irp_rom
  import irp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  src_e              src,
  input  logic [IDX_W-1:0]  idx,
  output logic [WORD_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (en) begin
      case (src)
        SRC_CROM: q <= crom_word(idx[5:0]);
        SRC_RROM: q <= rrom_word(idx);
        default:  q <= '0;
      endcase
    end
  end
endmodule

// File: rtl/irp_channel.sv
module irp_channel
  import irp_pkg::*;
#(
  parameter int GAIN_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  src_e              wr_src,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              snap_en,
  input  logic [GAIN_W-1:0] gain_in,
  input  logic              rd_en,
  input  src_e              rd_src,
  input  logic [IDX_W-1:0]  rd_idx,
  input  src_e              live_src,
  output logic [WORD_W-1:0] live_data,
  output logic [WORD_W-1:0] mem_q
);
  logic [WORD_W-1:0] cnco_q, wait_q, tnco_q;
  logic [GAIN_W-1:0] gain_snap_q;
  logic [WORD_W-1:0] iram [IRAM_DEPTH];
  logic [WORD_W-1:0] cram1 [CRAM1_DEPTH];
  logic [WORD_W-1:0] cram2 [CRAM2_DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnco_q      <= '0;
      wait_q      <= '0;
      tnco_q      <= '0;
      gain_snap_q <= '0;
    end else begin
      if (wr_en && wr_src == SRC_CNCO) cnco_q <= wr_data;
      if (wr_en && wr_src == SRC_WAIT) wait_q <= wr_data;
      if (wr_en && wr_src == SRC_TNCO) tnco_q <= wr_data;
      if (snap_en) gain_snap_q <= gain_in;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      case (wr_src)
        SRC_IRAM:  iram[wr_idx[IRAM_AW-1:0]]   <= wr_data;
        SRC_CRAM1: cram1[wr_idx[CRAM1_AW-1:0]] <= wr_data;
        SRC_CRAM2: cram2[wr_idx[CRAM2_AW-1:0]] <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (rd_en) begin
      case (rd_src)
        SRC_IRAM:  mem_q <= iram[rd_idx[IRAM_AW-1:0]];
        SRC_CRAM1: mem_q <= cram1[rd_idx[CRAM1_AW-1:0]];
        SRC_CRAM2: mem_q <= cram2[rd_idx[CRAM2_AW-1:0]];
        default:   mem_q <= '0;
      endcase
    end
  end

  always_comb begin
    case (live_src)
      SRC_CNCO: live_data = cnco_q;
      SRC_WAIT: live_data = wait_q;
      SRC_TNCO: live_data = tnco_q;
      SRC_AGC:  live_data = WORD_W'(gain_snap_q);
      default:  live_data = '0;
    endcase
  end
endmodule

// File: rtl/indirect_read_port.sv
module indirect_read_port
  import irp_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int GAIN_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            host_addr,
  input  logic [HALF_W-1:0]     host_wdata,
  input  logic                  host_we,
  output logic [HALF_W-1:0]     host_rdata,
  input  logic [NCH*GAIN_W-1:0] agc_gain_in,
  output logic                  fetch_stb
);
  logic [HALF_W-1:0] stage_lo_q, stage_hi_q;
  logic [HALF_W-1:0] sel_q;
  logic              fetch_q;
  logic [WORD_W-1:0] hold_q, hold_d;

  logic iwa_wr, ira_wr;
  assign iwa_wr = host_we && (host_addr == DA_IWA);
  assign ira_wr = host_we && (host_addr == DA_IRA);

  // incoming indirect address (either commit or select)
  src_e             in_src;
  logic [IDX_W-1:0] in_idx;
  logic             in_strobed;
  logic [NIB_W-1:0] in_nib;
  logic             in_nib_ok, fetch_req, snap;

  irp_decode u_in_dec (
    .off(host_wdata[OFF_W-1:0]), .src(in_src), .idx(in_idx), .strobed(in_strobed)
  );

  assign in_nib    = host_wdata[HALF_W-1 -: NIB_W];
  assign in_nib_ok = (in_nib == NIB_ALL) || (int'(in_nib) < NCH);
  assign fetch_req = ira_wr && in_strobed && in_nib_ok;
  assign snap      = iwa_wr && (in_src == SRC_AGC);

  // currently selected source
  src_e             sel_src;
  logic [IDX_W-1:0] sel_idx;
  logic             sel_strobed;
  logic [NIB_W-1:0] sel_nib;
  logic             sel_nib_ok;

  irp_decode u_sel_dec (
    .off(sel_q[OFF_W-1:0]), .src(sel_src), .idx(sel_idx), .strobed(sel_strobed)
  );

  assign sel_nib    = sel_q[HALF_W-1 -: NIB_W];
  assign sel_nib_ok = (sel_nib == NIB_ALL) || (int'(sel_nib) < NCH);

  logic [NCH-1:0]    ch_wr, ch_rd;
  logic [WORD_W-1:0] ch_live [NCH];
  logic [WORD_W-1:0] ch_mem  [NCH];
  logic [WORD_W-1:0] rom_q;

  genvar c;
  generate
    for (c = 0; c < NCH; c++) begin : g_ch
      assign ch_wr[c] = iwa_wr && ((in_nib == NIB_ALL) || (int'(in_nib) == c));
      assign ch_rd[c] = fetch_req &&
                        ((int'(in_nib) == c) || (in_nib == NIB_ALL && c == 0));
      irp_channel #(.GAIN_W(GAIN_W)) u_chan (
        .clk(clk), .rst_n(rst_n),
        .wr_en(ch_wr[c]), .wr_src(in_src), .wr_idx(in_idx),
        .wr_data({stage_hi_q, stage_lo_q}),
        .snap_en(snap), .gain_in(agc_gain_in[c*GAIN_W +: GAIN_W]),
        .rd_en(ch_rd[c]), .rd_src(in_src), .rd_idx(in_idx),
        .live_src(sel_src),
        .live_data(ch_live[c]), .mem_q(ch_mem[c])
      );
    end
  endgenerate

  irp_rom u_rom (
    .clk(clk), .rst_n(rst_n), .en(fetch_req), .src(in_src), .idx(in_idx), .q(rom_q)
  );

  logic [WORD_W-1:0] pick_live, pick_mem;
  always_comb begin
    pick_live = '0;
    pick_mem  = '0;
    for (int k = 0; k < NCH; k++) begin
      if ((int'(sel_nib) == k) || (sel_nib == NIB_ALL && k == 0)) begin
        pick_live = ch_live[k];
        pick_mem  = ch_mem[k];
      end
    end
  end

  always_comb begin
    hold_d = hold_q;
    if (!sel_nib_ok)      hold_d = '0;
    else if (sel_strobed) begin
      if (fetch_q) hold_d = src_is_rom(sel_src) ? rom_q : pick_mem;
    end else              hold_d = pick_live;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_lo_q <= '0;
      stage_hi_q <= '0;
      sel_q      <= '0;
      fetch_q    <= 1'b0;
      hold_q     <= '0;
    end else begin
      if (host_we && host_addr == DA_WD_LO) stage_lo_q <= host_wdata;
      if (host_we && host_addr == DA_WD_HI) stage_hi_q <= host_wdata;
      if (ira_wr) sel_q <= host_wdata;
      fetch_q <= fetch_req;
      hold_q  <= hold_d;
    end
  end

  assign fetch_stb = fetch_q;

  always_comb begin
    case (host_addr)
      DA_RD_LO: host_rdata = hold_q[HALF_W-1:0];
      DA_RD_HI: host_rdata = hold_q[WORD_W-1:HALF_W];
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/irp_checker.sv
module irp_checker #(
  parameter int NCH = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  host_addr,
  input logic        host_we,
  input logic [15:0] host_rdata,
  input logic        fetch_stb,
  input logic [3:0]  sel_nib,
  input logic        sel_strobed,
  input logic [31:0] hold_q
);
  logic bad_nib;
  assign bad_nib = (sel_nib != 4'hF) && (int'(sel_nib) >= NCH);

  assert_rdata_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_addr > 3'd1) |-> (host_rdata == 16'h0000));

  assert_strobe_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> $past(host_we && host_addr == 3'd3));

  assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |=> (!fetch_stb || $past(host_we && host_addr == 3'd3)));

  assert_strobe_mem_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_stb |-> sel_strobed);

  assert_hold_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_strobed && !fetch_stb && !bad_nib) |=> $stable(hold_q));

  assert_bad_nib_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bad_nib |=> (hold_q == 32'h0));
endmodule

bind indirect_read_port irp_checker #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_we(host_we),
  .host_rdata(host_rdata), .fetch_stb(fetch_stb), .sel_nib(sel_q[15:12]),
  .sel_strobed(sel_strobed), .hold_q(hold_q)
);

// File: tb/indirect_read_port_tb.sv
module indirect_read_port_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  host_addr = 3'd0;
  logic [15:0] host_wdata = 16'h0;
  logic        host_we = 1'b0;
  logic [15:0] host_rdata;
  logic [63:0] agc_gain_in = 64'h0;
  logic        fetch_stb;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  typedef struct {
    bit          kind;
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];

  always #5 clk = ~clk;

  indirect_read_port u_dut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_we(host_we), .host_rdata(host_rdata), .agc_gain_in(agc_gain_in),
    .fetch_stb(fetch_stb)
  );

  function automatic logic [31:0] crom_ref(input int i);
    logic [15:0] a, b;
    a = 16'(i * i);
    b = 16'hC000 | 16'(i);
    return {a, b};
  endfunction

  function automatic logic [31:0] rrom_ref(input int j);
    logic [7:0] a;
    a = 8'(j);
    return {a, ~a, 16'(3 * j)};
  endfunction

  // monitor: compares queued expectations at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        item_t it;
        logic [15:0] act;
        it = sb.pop_front();
        act = it.kind ? {15'd0, fetch_stb} : host_rdata;
        total++;
        if (act !== it.exp) begin
          bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    host_addr = a; host_wdata = d; host_we = 1'b1;
    @(posedge clk); #1;
    host_we = 1'b0;
  endtask

  task automatic iw(input logic [3:0] nib, input logic [11:0] off, input logic [31:0] d);
    wr(3'd4, d[15:0]);
    wr(3'd5, d[31:16]);
    wr(3'd2, {nib, off});
  endtask

  task automatic sel(input logic [3:0] nib, input logic [11:0] off);
    wr(3'd3, {nib, off});
  endtask

  task automatic chk_stb(input bit e, input string tag);
    item_t it;
    it.kind = 1'b1; it.exp = {15'd0, e}; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic chk_rd(input logic [2:0] a, input logic [15:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    host_addr = a;
    it.kind = 1'b0; it.exp = e; it.tag = tag;
    sb.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic rd32(input logic [31:0] e, input string tag);
    chk_rd(3'd0, e[15:0], tag);
    chk_rd(3'd1, e[31:16], tag);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk_stb(1'b0, "R1 strobe after reset");
    rd32(32'h0, "R1 hold after reset");

    // R2/R5 live register per channel
    iw(4'h0, 12'h006, 32'h12345678);
    iw(4'h1, 12'h006, 32'h9ABCDEF0);
    sel(4'h0, 12'h006);
    chk_stb(1'b0, "R3 no strobe for live source");
    rd32(32'h12345678, "R2 carrier word ch0");
    chk_rd(3'd6, 16'h0000, "R2 unused location reads zero");
    sel(4'h1, 12'h006);
    rd32(32'h9ABCDEF0, "R6 carrier word ch1");
    iw(4'h1, 12'h006, 32'h0BADF00D);
    rd32(32'h0BADF00D, "R5 live change without reselect");

    // R6 broadcast and invalid nibble
    iw(4'hF, 12'h00C, 32'hCAFE0001);
    sel(4'h2, 12'h00C);
    rd32(32'hCAFE0001, "R6 broadcast reaches ch2");
    sel(4'h3, 12'h00C);
    rd32(32'hCAFE0001, "R6 broadcast reaches ch3");
    iw(4'h1, 12'h00C, 32'h00000777);
    sel(4'hF, 12'h006);
    rd32(32'h12345678, "R6 nibble F reads ch0");
    iw(4'h5, 12'h009, 32'h11112222);
    sel(4'h0, 12'h009);
    rd32(32'h0, "R6 write with nibble 5 dropped");
    sel(4'h5, 12'h006);
    rd32(32'h0, "R6 read with nibble 5 is zero");

    // R3/R4 strobed RAM
    iw(4'h2, 12'h445, 32'hA1B2C3D4);
    sel(4'h2, 12'h445);
    chk_stb(1'b1, "R3 strobe for RAM source");
    rd32(32'hA1B2C3D4, "R3 RAM A word");
    chk_stb(1'b0, "R3 strobe lasts one cycle");
    iw(4'h2, 12'h445, 32'h55556666);
    rd32(32'hA1B2C3D4, "R4 held value without reselect");
    sel(4'h2, 12'h445);
    rd32(32'h55556666, "R4 refetch after reselect");
    iw(4'h3, 12'h4FF, 32'h0F0F1234);
    sel(4'h3, 12'h4FF);
    rd32(32'h0F0F1234, "R3 RAM B last word");
    iw(4'h1, 12'h1FC, 32'h76543210);
    iw(4'h1, 12'h100, 32'h00C0FFEE);
    sel(4'h1, 12'h1FC);
    rd32(32'h76543210, "R3 instruction RAM last word");
    sel(4'h1, 12'h100);
    rd32(32'h00C0FFEE, "R3 instruction RAM first word");

    // R7 unmapped and ROM writes
    sel(4'h0, 12'h1FD);
    chk_stb(1'b0, "R7 no strobe for unmapped");
    rd32(32'h0, "R7 unmapped 1FD");
    sel(4'h0, 12'h300);
    rd32(32'h0, "R7 unmapped 300");
    iw(4'h0, 12'h400, 32'hDEADBEEF);
    sel(4'h0, 12'h400);
    rd32(crom_ref(0), "R7 ROM write ignored");

    // R10 ROM contents
    sel(4'h1, 12'h43F);
    rd32(crom_ref(63), "R10 coefficient ROM 63");
    sel(4'h2, 12'h5FF);
    rd32(rrom_ref(255), "R10 resampler ROM 255");
    sel(4'h3, 12'h52A);
    rd32(rrom_ref(42), "R10 resampler ROM 42");

    // R8/R9/R11 gain snapshot
    agc_gain_in = 64'h4444_3333_2222_1111;
    iw(4'h7, 12'h00F, 32'hFFFFFFFF);
    agc_gain_in = 64'h9999_8888_7777_6666;
    sel(4'h0, 12'h00F);
    rd32(32'h00001111, "R8 snapshot ch0");
    sel(4'h3, 12'h00F);
    rd32(32'h00004444, "R9 snapshot ch3 not live");
    sel(4'h2, 12'h00F);
    chk_rd(3'd1, 16'h0000, "R11 gain upper half zero");
    chk_rd(3'd0, 16'h3333, "R8 snapshot ch2");

    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule